// File: doc/BRIEF.md
# Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. It has two parts. A datapath holds two working registers, a subtractor feeding each of them, two comparators and a result register. A separate controller sequences the datapath through a fixed set of binary-encoded states. The controller acts only on the start request and on two status flags from the datapath: "operands differ" and "first operand is smaller".

To use it, present both operands and raise `start`. Keep the operands steady until the engine has captured them. When the result is ready, `done` pulses for one cycle and `gcd_out` carries the result. `gcd_out` keeps that value until the next result replaces it. If one operand is zero, the other operand is taken as the result, so the loop always ends.

Top module: `gcd_engine`

## Requirements
- R1: While `start` is low and no computation is running, the engine starts nothing: `done` stays low and `gcd_out` keeps its value.
- R2: Operand A is captured in one cycle and operand B in the following cycle. Changes to `opnd_a` or `opnd_b` after both captures do not affect the result of the current computation.
- R3: Each loop step subtracts the smaller working value from the larger one. Neither working register ever wraps below zero.
- R4: The result register is loaded only when both working values are equal. For nonzero operands, `gcd_out` then equals their greatest common divisor.
- R5: `done` is high for exactly one cycle, the cycle after the result register is loaded. `gcd_out` is stable at every other time.
- R6: A zero operand yields the other operand as the result. Two zero operands yield 0.
- R7: Synchronous active-high `rst` clears `gcd_out` to 0, drives `done` low and returns the controller to its initial state, even in the middle of a computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a computation, sampled in the idle state |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| gcd_out | output | 8 | Last computed result |
| done | output | 1 | One-cycle pulse: a new result is on `gcd_out` |

## Verification
The bench uses a set of directed pairs, each aimed at a different path:
- (42,8) walks both subtraction branches several times.
- Equal operands skip the loop entirely.
- (255,1) gives the longest run of one-sided subtractions.
- Pairs with a zero operand take the substitution path, and reversing such a pair shows whether both load positions handle it.

Random pairs drawn from a seeded generator then cover general mixes of the two branches. Each result is compared with a modulo-based reference. Every run also scrambles the operand inputs once the captures are over, which exposes a datapath that keeps reading its inputs. A reset issued mid-computation, followed by a long idle period with `start` low, shows whether the engine restarts on its own.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    localparam int DATA_W = 8;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_BOOT     = 4'd0,
        ST_IDLE     = 4'd1,
        ST_IDLE_RET = 4'd2,
        ST_GET_A    = 4'd3,
        ST_GET_B    = 4'd4,
        ST_CHECK    = 4'd5,
        ST_ORDER    = 4'd6,
        ST_SUB_B    = 4'd7,
        ST_SUB_A    = 4'd8,
        ST_MERGE    = 4'd9,
        ST_LOOP_RET = 4'd10,
        ST_EMIT     = 4'd11,
        ST_EMIT_RET = 4'd12
    } state_e;

    typedef struct packed {
        logic a_ld;
        logic a_from_sub;
        logic b_ld;
        logic b_from_sub;
        logic res_ld;
    } ctl_t;

    typedef struct packed {
        logic differ;
        logic a_below_b;
    } flags_t;

    function automatic ctl_t decode_ctl(state_e s);
        ctl_t c;
        c = '0;
        unique case (s)
            ST_GET_A: c.a_ld = 1'b1;
            ST_GET_B: c.b_ld = 1'b1;
            ST_SUB_B: begin c.b_ld = 1'b1; c.b_from_sub = 1'b1; end
            ST_SUB_A: begin c.a_ld = 1'b1; c.a_from_sub = 1'b1; end
            ST_EMIT:  c.res_ld = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  flags_t flags,
    output ctl_t   ctl
);

    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:     state_d = ST_IDLE;
            ST_IDLE:     state_d = start ? ST_GET_A : ST_IDLE_RET;
            ST_IDLE_RET: state_d = ST_IDLE;
            ST_GET_A:    state_d = ST_GET_B;
            ST_GET_B:    state_d = ST_CHECK;
            ST_CHECK:    state_d = flags.differ ? ST_ORDER : ST_EMIT;
            ST_ORDER:    state_d = flags.a_below_b ? ST_SUB_B : ST_SUB_A;
            ST_SUB_B:    state_d = ST_MERGE;
            ST_SUB_A:    state_d = ST_MERGE;
            ST_MERGE:    state_d = ST_LOOP_RET;
            ST_LOOP_RET: state_d = ST_CHECK;
            ST_EMIT:     state_d = ST_EMIT_RET;
            ST_EMIT_RET: state_d = ST_BOOT;
            default:     state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BOOT;
        else     state_q <= state_d;
    end

    assign ctl = decode_ctl(state_q);

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> !ctl.a_ld && !ctl.b_ld); // R1

    AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (ctl.a_ld && !ctl.a_from_sub) |=> (ctl.b_ld && !ctl.b_from_sub)); // R2

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.a_ld, ctl.b_ld, ctl.res_ld})); // R3

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output flags_t       flags,
    output logic [W-1:0] result,
    output logic         done
);

    logic [W-1:0] a_q, b_q, res_q;
    logic         done_q;
    logic [W-1:0] a_diff, b_diff, a_in, b_in, a_d, b_d;

    // subtractors, one per working register
    assign a_diff = a_q - b_q;
    assign b_diff = b_q - a_q;

    // zero substitution: a zero operand takes the other one, loop exits at once
    assign a_in = (opnd_a == '0) ? opnd_b : opnd_a;
    assign b_in = (opnd_b == '0) ? opnd_a : opnd_b;

    assign a_d = ctl.a_from_sub ? a_diff : a_in;
    assign b_d = ctl.b_from_sub ? b_diff : b_in;

    // comparators
    assign flags.differ    = (a_q != b_q);
    assign flags.a_below_b = (a_q < b_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (ctl.a_ld)   a_q   <= a_d;
            if (ctl.b_ld)   b_q   <= b_d;
            if (ctl.res_ld) res_q <= a_q;
            done_q <= ctl.res_ld;
        end
    end

    assign result = res_q;
    assign done   = done_q;

    AST_A_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.a_ld && ctl.a_from_sub) |-> (a_q > b_q)); // R3

    AST_B_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.b_ld && ctl.b_from_sub) |-> (b_q > a_q)); // R3

    AST_EMIT_EQUAL: assert property (@(posedge clk) disable iff (rst)
        ctl.res_ld |-> (a_q == b_q)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.res_ld |=> $stable(res_q)); // R5

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
    import gcd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] gcd_out,
    output logic         done
);

    ctl_t   ctl;
    flags_t flags;

    gcd_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .flags (flags),
        .ctl   (ctl)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .flags  (flags),
        .result (gcd_out),
        .done   (done)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (gcd_out == '0 && !done)); // R7

endmodule

// File: tb/tb_gcd_engine.sv
`timescale 1ns/1ps
module tb_gcd_engine;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] gcd_out;
    logic         done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    gcd_engine #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .gcd_out(gcd_out), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] ref_gcd(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] x, y, t;
        x = a; y = b;
        while (y != 0) begin
            t = x % y; x = y; y = t;
        end
        return x;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_pair(logic [W-1:0] a, logic [W-1:0] b, string req);
        logic [W-1:0] got;
        int n;
        @(negedge clk);
        opnd_a = a; opnd_b = b; start = 1'b1;
        repeat (4) @(negedge clk);
        // R2: captures are over, scramble the operand inputs
        opnd_a = ~a; opnd_b = a ^ 8'h5a;
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        start = 1'b0;
        if (!done) begin
            checks++; fails++;
            $display("FAIL %s: actual no done expected done for (%0d,%0d)", req, a, b);
            return;
        end
        check(req, gcd_out, ref_gcd(a, b)); // R3 R4 R2
        got = gcd_out;
        @(negedge clk);
        check("R5 done width", {7'd0, done}, 8'd0);
        repeat (3) @(negedge clk);
        check("R5 hold", gcd_out, got);
    endtask

    initial begin
        int seed_dummy;
        logic [W-1:0] held;
        bit seen;
        seed_dummy = $urandom(32'h1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R7 reset out", gcd_out, 8'd0);
        check("R7 reset done", {7'd0, done}, 8'd0);

        // R1: idle with start low
        seen = 0;
        repeat (40) begin @(negedge clk); if (done) seen = 1; end
        check("R1 idle done", {7'd0, seen}, 8'd0);
        check("R1 idle out", gcd_out, 8'd0);

        run_pair(8'd42, 8'd8, "R3 (42,8)");
        run_pair(8'd9, 8'd9, "R4 equal");
        run_pair(8'd1, 8'd200, "R3 one");
        run_pair(8'd255, 8'd1, "R3 long");
        run_pair(8'd128, 8'd64, "R4 power");
        run_pair(8'd0, 8'd7, "R6 zero a");
        run_pair(8'd7, 8'd0, "R6 zero b");
        run_pair(8'd0, 8'd0, "R6 both zero");
        run_pair(8'd221, 8'd187, "R4 coprime-ish");

        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom_range(1, 255));
            rb = W'($urandom_range(1, 255));
            run_pair(ra, rb, "R4 random");
        end

        // R1: after a result, idle must not restart nor change output
        held = gcd_out;
        seen = 0;
        repeat (40) begin @(negedge clk); if (done) seen = 1; end
        check("R1 no restart", {7'd0, seen}, 8'd0);
        check("R1 out kept", gcd_out, held);

        // R7: reset in the middle of a computation
        @(negedge clk);
        opnd_a = 8'd200; opnd_b = 8'd3; start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R7 mid reset out", gcd_out, 8'd0);
        seen = 0;
        repeat (60) begin @(negedge clk); if (done) seen = 1; end
        check("R7 no resume", {7'd0, seen}, 8'd0);

        run_pair(8'd60, 8'd48, "R7 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule